// File: doc/BRIEF.md
# Big-Endian Byte and Word Load/Store Aligner

This unit sits between a 32-bit core and a word-wide data memory. For each access it forms the byte address as a base value plus a sign-extended constant offset. On a store it drives byte-lane write enables and places the data on the right lanes. On a load it takes the memory's read word one cycle later, picks out the addressed byte or the whole word and returns it right-justified. A byte is widened by copying its sign bit or by padding with zeros, as the request asks.

Lanes follow big-endian order: the lowest byte address in a word names its most significant byte. A word access whose address is not a multiple of four is only flagged. It performs no write and returns no load.

Top module: `be_lsu_aligner`

## Requirements
- R1: `mem_addr` equals `base + offset`, with `offset` sign-extended from OFFSET_W bits, computed combinationally in the cycle of the request.
- R2: Big-endian lanes. Address bits [1:0] equal to 0, 1, 2 and 3 select read bits [31:24], [23:16], [15:8] and [7:0] respectively. A word 0x12345678 written at address 4 reads back byte 0x12 at address 4 and byte 0x78 at address 7.
- R3: A signed byte load (`req_word`=0, `req_signed`=1) returns the byte in bits [7:0] with bits [31:8] all equal to bit 7. Byte 0x81 gives 0xFFFFFF81.
- R4: An unsigned byte load (`req_signed`=0) returns the byte in bits [7:0] with bits [31:8] zero. Byte 0x81 gives 0x00000081.
- R5: A byte store drives a one-hot `mem_we`. Bit 3 enables bits [31:24] and bit 0 enables bits [7:0], so address bits [1:0]=k give `mem_we` = 4'b1000 >> k. `mem_wdata` holds the store byte copied onto all four lanes.
- R6: A byte store changes only the addressed byte; the other three bytes of the word read back unchanged.
- R7: An aligned word store drives `mem_we`=4'b1111 with `mem_wdata`=`store_data`. An aligned word load returns the full read word.
- R8: A word access with address bits [1:0] not zero raises `misaligned` in the request cycle. It drives `mem_we`=0 and `mem_en`=0, and produces no `load_valid`. Byte accesses never raise `misaligned`.
- R9: `load_valid` is high exactly in the cycle after an accepted load request, with `load_data` valid in that cycle. It is low after reset and after stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_signed | input | 1 | Byte loads: 1 = sign-extend, 0 = zero-extend |
| base | input | 32 | Base address value |
| offset | input | OFFSET_W | Signed byte offset |
| store_data | input | 32 | Store value (byte stores use bits [7:0]) |
| mem_addr | output | 32 | Effective byte address |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 4 | Byte-lane write enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Write data to memory |
| misaligned | output | 1 | Unaligned word access flag |
| mem_rdata | input | 32 | Read word, returned the cycle after `mem_en` |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Aligned and extended load result |

## Verification
The bench builds the block with the default 16-bit offset and pairs it with a four-word memory model. Every byte address of the 16 in that model is reached through several base and offset pairs, with negative offsets among them. This covers all four lanes in each word, both extension modes with bytes of either sign, and every unaligned word address. A shadow byte array makes read-back after partial stores prove that untouched lanes are preserved.

// File: rtl/be_lsu_aligner.sv
module be_lsu_aligner #(
  parameter int OFFSET_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_store,
  input  logic                req_word,
  input  logic                req_signed,
  input  logic [31:0]         base,
  input  logic [OFFSET_W-1:0] offset,
  input  logic [31:0]         store_data,
  output logic [31:0]         mem_addr,
  output logic                mem_en,
  output logic [3:0]          mem_we,
  output logic [31:0]         mem_wdata,
  output logic                misaligned,
  input  logic [31:0]         mem_rdata,
  output logic                load_valid,
  output logic [31:0]         load_data
);
  localparam int EXT_W = 32 - OFFSET_W;

  logic [1:0] lane;
  logic       accept;
  logic [1:0] lane_q;
  logic       word_q;
  logic       signed_q;
  logic [7:0] byte_sel;

  assign mem_addr   = base + {{EXT_W{offset[OFFSET_W-1]}}, offset};
  assign lane       = mem_addr[1:0];
  assign misaligned = req_valid && req_word && (lane != 2'd0);
  assign accept     = req_valid && !misaligned;
  assign mem_en     = accept;
  assign mem_we     = (accept && req_store) ? (req_word ? 4'b1111 : (4'b1000 >> lane)) : 4'b0000;
  assign mem_wdata  = req_word ? store_data : {4{store_data[7:0]}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_valid <= 1'b0;
      lane_q     <= 2'd0;
      word_q     <= 1'b0;
      signed_q   <= 1'b0;
    end else begin
      load_valid <= accept && !req_store;
      if (accept && !req_store) begin
        lane_q   <= lane;
        word_q   <= req_word;
        signed_q <= req_signed;
      end
    end
  end

  always_comb begin
    case (lane_q)
      2'd0:    byte_sel = mem_rdata[31:24];
      2'd1:    byte_sel = mem_rdata[23:16];
      2'd2:    byte_sel = mem_rdata[15:8];
      default: byte_sel = mem_rdata[7:0];
    endcase
  end

  assign load_data = word_q ? mem_rdata : {{24{signed_q & byte_sel[7]}}, byte_sel};

  assert_byte_store_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !req_word) |-> ($countones(mem_we) == 1));

  assert_misaligned_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (mem_we == 4'b0000 && !mem_en));

  assert_misaligned_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |=> !load_valid);

  assert_word_store_all_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_word && !misaligned) |-> (mem_we == 4'b1111));

  assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && !req_word && !req_signed) |=> (load_valid && load_data[31:8] == 24'h0));

  assert_sign_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && !req_word && req_signed) |=> (load_valid && load_data[31:8] == {24{load_data[7]}}));

  assert_store_no_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store) |=> !load_valid);
endmodule

// File: tb/tb_be_lsu_aligner.sv
module tb_be_lsu_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int OW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, req_word = 1'b0, req_signed = 1'b0;
  logic [31:0] base = '0;
  logic [OW-1:0] offset = '0;
  logic [31:0] store_data = '0;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic [31:0] mem_rdata = '0;
  logic mem_en, misaligned, load_valid;
  logic [3:0] mem_we;

  logic [31:0] mem [4];
  logic [7:0]  shadow [16];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  be_lsu_aligner #(.OFFSET_W(OW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_word(req_word), .req_signed(req_signed), .base(base), .offset(offset),
    .store_data(store_data), .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .misaligned(misaligned), .mem_rdata(mem_rdata),
    .load_valid(load_valid), .load_data(load_data)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      for (int l = 0; l < 4; l++)
        if (mem_we[l]) mem[mem_addr[3:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
      mem_rdata <= mem[mem_addr[3:2]];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit st, input bit wd, input bit sg,
                        input logic [31:0] b, input logic [OW-1:0] off, input logic [31:0] sd);
    logic [31:0] ea;
    logic        mis;
    logic [3:0]  we_exp;
    logic [31:0] exp_ld;
    logic [7:0]  bv;
    int          a;
    ea  = b + {{(32-OW){off[OW-1]}}, off};
    mis = wd && (ea[1:0] != 2'd0);
    a   = int'(ea[3:0]);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_word = wd; req_signed = sg;
    base = b; offset = off; store_data = sd;
    #1;
    check("R1 mem_addr", mem_addr, ea);
    check("R8 misaligned", {31'd0, misaligned}, {31'd0, mis});
    if (st) begin
      we_exp = mis ? 4'b0000 : (wd ? 4'b1111 : (4'b1000 >> ea[1:0]));
      check(wd ? "R7 word we" : "R5 byte we", {28'd0, mem_we}, {28'd0, we_exp});
      if (!mis) begin
        check(wd ? "R7 word wdata" : "R5 replicated wdata", mem_wdata, wd ? sd : {4{sd[7:0]}});
        if (wd) begin
          shadow[a] = sd[31:24]; shadow[a+1] = sd[23:16];
          shadow[a+2] = sd[15:8]; shadow[a+3] = sd[7:0];
        end else shadow[a] = sd[7:0];
      end
    end else if (mis) begin
      check("R8 no enable", {31'd0, mem_en}, 32'd0);
    end
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
    if (!st && !mis) begin
      if (wd) exp_ld = {shadow[a], shadow[a+1], shadow[a+2], shadow[a+3]};
      else begin
        bv = shadow[a];
        exp_ld = sg ? {{24{bv[7]}}, bv} : {24'd0, bv};
      end
      check("R9 load_valid", {31'd0, load_valid}, 32'd1);
      check(wd ? "R7 word load" : (sg ? "R3 signed byte R2 lane R6" : "R4 unsigned byte R2 lane R6"),
            load_data, exp_ld);
    end else begin
      check(mis ? "R8 no load_valid" : "R9 no load_valid after store", {31'd0, load_valid}, 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mem[i] = '0;
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    check("R9 reset load_valid", {31'd0, load_valid}, 32'd0);
    check("R8 reset misaligned", {31'd0, misaligned}, 32'd0);
    rst_n = 1'b1;

    for (int w = 0; w < 4; w++)
      access(1, 1, 0, 32'd100, 16'(w*4 - 100), 32'hA5000000 + 32'(w * 32'h01030507));
    for (int w = 0; w < 4; w++) access(0, 1, 0, 32'd0, 16'(w*4), 32'd0);

    access(1, 1, 0, 32'd8, 16'hFFFC, 32'h12345678);
    access(0, 0, 0, 32'd4, 16'd0, 32'd0);
    check("R2 byte at 4 is 0x12", load_data, 32'h00000012);
    access(0, 0, 0, 32'd10, 16'hFFFD, 32'd0);
    check("R2 byte at 7 is 0x78", load_data, 32'h00000078);

    for (int a = 0; a < 16; a++) begin
      if (a[1:0] != 2'd0) begin
        access(1, 1, 0, 32'(a), 16'd0, 32'hDEADBEEF);
        access(0, 1, 0, 32'(a + 3), 16'hFFFD, 32'd0);
      end
    end

    for (int a = 0; a < 16; a++) begin
      for (int k = 0; k < 3; k++) begin
        access(1, 0, 0, 32'(a + 40*k), 16'(-40*k), 32'hFFFFFF00 | 32'((a*37 + k*91 + 3) & 255));
        access(0, 0, 1, 32'(a + 7), 16'hFFF9, 32'd0);
        access(0, 0, 0, 32'd0, 16'(a), 32'd0);
        access(0, 1, 0, 32'd0, 16'(a & 12), 32'd0);
      end
    end

    access(1, 0, 0, 32'd2, 16'd0, 32'h00000081);
    access(0, 0, 1, 32'd2, 16'd0, 32'd0);
    check("R3 0x81 signed", load_data, 32'hFFFFFF81);
    access(0, 0, 0, 32'd2, 16'd0, 32'd0);
    check("R4 0x81 unsigned", load_data, 32'h00000081);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule